// File: doc/BRIEF.md
# Multi-Mode Local Interrupt Timer

A per-core timer that raises a one-cycle interrupt request carrying an 8-bit vector. It has three modes, chosen by a field in its timer control register. In one-shot mode it counts one programmed span and then goes idle. In periodic mode it repeats the span without stopping. In absolute-deadline mode it compares a 64-bit deadline against a free-running timestamp input.

Software reaches the block through two ports. A small 32-bit register port holds the control register, the start count, the live count and the divide setting. A separate 64-bit port holds the deadline. The current mode decides which of these registers respond. A strap input reports whether the deadline mode exists at all. Delivery and arbitration of the request happen outside the block.

Top module: `lvt_irq_timer`

## Requirements
- R1: The register port decodes address 0 as the control register, 1 as the start count, 2 as the live count and 3 as the divide setting. The control register holds the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17. All other bits are dropped on write and read as 0. After reset the control register reads 0x0001_0000.
- R2: When `dl_cap_i` is 0, bit 18 of a control write is stored as 0. Only bit 17 of the mode can then be set.
- R3: When `sw_en_i` is 0, every control write stores the mask bit as 1.
- R4: A control write whose mode differs from the stored mode cancels any armed countdown or deadline. A control write that keeps the same mode leaves an armed expiry running.
- R5: Mode 00 is one-shot. A nonzero start-count write of N with divide code d (bits 2:0 of the divide register, factor 2^d) raises `irq_o` N*2^d cycles after the accepting edge. `irq_vec_o` then carries the stored vector, and the timer disarms.
- R6: The live-count register reads the remaining cycles shifted right by d. It reads 0 when the timer is idle and at all times in deadline mode.
- R7: A start-count write cancels the countdown in progress. A write of 0 leaves the timer idle.
- R8: Mode 01 is periodic. The timer reloads on every expiry. The span N*2^d is raised to MIN_PERIOD (default 16) when it is shorter, and this applies to the first span too.
- R9: With the mask bit set, an expiry produces no request, but one-shot still disarms and periodic still reloads.
- R10: Mode 10 is deadline. Writing deadline D arms the timer, and the request is raised on the first clock edge at which `tsc_i` >= D. A new write replaces the old deadline. D = 0 leaves the timer disarmed. A deadline that has already passed fires one cycle after the write. The timer disarms after it fires.
- R11: In deadline mode, writes to the start count are ignored.
- R12: Outside deadline mode, `dl_rdata_o` reads 0 and deadline writes are ignored.
- R13: Each request lasts exactly one cycle.
- R14: Mode 11 is reserved. In this mode no write arms the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software enable of the timer unit |
| dl_cap_i | input | 1 | Deadline capability strap |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dl_we_i | input | 1 | Deadline write strobe |
| dl_wdata_i | input | 64 | Deadline write data |
| dl_rdata_o | output | 64 | Deadline read data |
| tsc_i | input | 64 | Free-running timestamp |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vec_o | output | 8 | Vector that goes with the request |

## Verification
The single-cycle pulse property depends on MIN_PERIOD being at least 2. It also depends on the timestamp advancing monotonically, so that a deadline, once passed, stays passed. The bench keeps MIN_PERIOD at its default. It drives `tsc_i` from a counter that adds one each cycle, and it changes the two straps only between scenarios, when the timer is idle.

// File: rtl/lit_pkg.sv
package lit_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_DEADLINE = 2'b10,
    MODE_RSVD     = 2'b11
  } tmr_mode_e;

  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned MODE_LO  = 17;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_INIT = 2'd1;
  localparam logic [1:0] ADDR_CUR  = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;
endpackage

// File: rtl/lit_ctrl_reg.sv
module lit_ctrl_reg
  import lit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             mask_i,
  input  logic [1:0]       mode_i,
  input  logic             sw_en_i,
  input  logic             dl_cap_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             mask_o,
  output tmr_mode_e        mode_o,
  output logic             mode_chg_o,
  output logic [31:0]      rdata_o
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q;
  tmr_mode_e        mode_q;
  tmr_mode_e        mode_new;

  // deadline bit only writable with the capability strap
  assign mode_new   = tmr_mode_e'({dl_cap_i & mode_i[1], mode_i[0]});
  assign mode_chg_o = we_i && (mode_new != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      mode_q <= MODE_ONESHOT;
    end else if (we_i) begin
      vec_q  <= vec_i;
      mask_q <= mask_i | ~sw_en_i;
      mode_q <= mode_new;
    end
  end

  assign vec_o  = vec_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;

  always_comb begin
    rdata_o                       = '0;
    rdata_o[VEC_W-1:0]            = vec_q;
    rdata_o[MASK_BIT]             = mask_q;
    rdata_o[MODE_LO+1:MODE_LO]    = mode_q;
  end

  a_r3_mask_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sw_en_i) |=> mask_q);
  a_r2_no_deadline_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !dl_cap_i) |=> !mode_q[1]);
endmodule

// File: rtl/lit_countdown.sv
module lit_countdown #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SH_W       = 3,
  parameter int unsigned MIN_PERIOD = 16,
  localparam int unsigned REM_W     = CNT_W + (1 << SH_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             periodic_i,
  input  logic             cancel_i,
  output logic             fire_o,
  output logic [REM_W-1:0] remain_o
);
  logic [REM_W-1:0] remain_q, period_q, len_raw, len_eff;

  assign len_raw = REM_W'(init_i) << shift_i;
  always_comb begin
    len_eff = len_raw;
    if (init_i == '0)
      len_eff = '0;
    else if (periodic_i && len_raw < REM_W'(MIN_PERIOD))
      len_eff = REM_W'(MIN_PERIOD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      period_q <= '0;
    end else if (cancel_i) begin
      remain_q <= '0;
      period_q <= '0;
    end else if (start_i) begin
      remain_q <= len_eff;
      period_q <= len_eff;
    end else if (remain_q == REM_W'(1)) begin
      remain_q <= periodic_i ? period_q : '0;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - REM_W'(1);
    end
  end

  assign fire_o   = (remain_q == REM_W'(1)) && !start_i && !cancel_i;
  assign remain_o = remain_q;

  a_r5_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q > REM_W'(1) && !start_i && !cancel_i) |=> remain_q == $past(remain_q) - REM_W'(1));
  a_r8_reload_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && periodic_i) |=> remain_q >= REM_W'(MIN_PERIOD));
endmodule

// File: rtl/lit_deadline.sv
module lit_deadline #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [TS_W-1:0] wdata_i,
  input  logic            cancel_i,
  input  logic [TS_W-1:0] tsc_i,
  output logic            fire_o,
  output logic            armed_o,
  output logic [TS_W-1:0] value_o
);
  logic [TS_W-1:0] dl_q;
  logic            armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (we_i) dl_q <= wdata_i;
      if (cancel_i)    armed_q <= 1'b0;
      else if (we_i)   armed_q <= (wdata_i != '0);
      else if (fire_o) armed_q <= 1'b0;
    end
  end

  // a past deadline fires on the first compare
  assign fire_o  = armed_q && (tsc_i >= dl_q) && !we_i && !cancel_i;
  assign armed_o = armed_q;
  assign value_o = dl_q;

  a_r10_disarm_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
endmodule

// File: rtl/lvt_irq_timer.sv
module lvt_irq_timer
  import lit_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SH_W       = 3,
  parameter int unsigned TS_W       = 64,
  parameter int unsigned MIN_PERIOD = 16,
  localparam int unsigned REM_W     = CNT_W + (1 << SH_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_en_i,
  input  logic             dl_cap_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             dl_we_i,
  input  logic [TS_W-1:0]  dl_wdata_i,
  output logic [TS_W-1:0]  dl_rdata_o,
  input  logic [TS_W-1:0]  tsc_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  logic [VEC_W-1:0] vec;
  logic             mask, mode_chg;
  tmr_mode_e        mode;
  logic [31:0]      ctrl_rdata;
  logic             is_cd, is_dl, ctrl_we, start;
  logic [CNT_W-1:0] init_q;
  logic [SH_W-1:0]  div_q;
  logic             cd_fire, dl_fire, dl_armed;
  logic [REM_W-1:0] cd_remain, cur_full;
  logic [TS_W-1:0]  dl_value;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  assign is_cd   = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
  assign is_dl   = (mode == MODE_DEADLINE);
  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign start   = reg_we_i && (reg_addr_i == ADDR_INIT) && is_cd;

  lit_ctrl_reg i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we),
    .vec_i      (reg_wdata_i[VEC_W-1:0]),
    .mask_i     (reg_wdata_i[MASK_BIT]),
    .mode_i     (reg_wdata_i[MODE_LO+1:MODE_LO]),
    .sw_en_i    (sw_en_i),
    .dl_cap_i   (dl_cap_i),
    .vec_o      (vec),
    .mask_o     (mask),
    .mode_o     (mode),
    .mode_chg_o (mode_chg),
    .rdata_o    (ctrl_rdata)
  );

  lit_countdown #(.CNT_W(CNT_W), .SH_W(SH_W), .MIN_PERIOD(MIN_PERIOD)) i_cd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .init_i     (reg_wdata_i[CNT_W-1:0]),
    .shift_i    (div_q),
    .periodic_i (mode == MODE_PERIODIC),
    .cancel_i   (mode_chg),
    .fire_o     (cd_fire),
    .remain_o   (cd_remain)
  );

  lit_deadline #(.TS_W(TS_W)) i_dl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (dl_we_i && is_dl),
    .wdata_i  (dl_wdata_i),
    .cancel_i (mode_chg),
    .tsc_i    (tsc_i),
    .fire_o   (dl_fire),
    .armed_o  (dl_armed),
    .value_o  (dl_value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      div_q  <= '0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (start) init_q <= reg_wdata_i[CNT_W-1:0];
      if (reg_we_i && reg_addr_i == ADDR_DIV) div_q <= reg_wdata_i[SH_W-1:0];
      irq_q <= (cd_fire || dl_fire) && !mask;
      vec_q <= vec;
    end
  end

  assign cur_full = cd_remain >> div_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_rdata;
      ADDR_INIT: reg_rdata_o = 32'(init_q);
      ADDR_CUR:  reg_rdata_o = is_dl ? 32'd0 : 32'(cur_full[CNT_W-1:0]);
      default:   reg_rdata_o = 32'(div_q);
    endcase
  end

  assign dl_rdata_o = is_dl ? dl_value : '0;
  assign irq_o      = irq_q;
  assign irq_vec_o  = vec_q;

  a_r13_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r11_no_count_in_deadline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dl |-> cd_remain == '0);
  a_r12_deadline_idle_elsewhere: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_dl |-> !dl_armed);
  a_r14_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_RSVD) |-> (cd_remain == '0 && !dl_armed));
endmodule

// File: tb/test_lvt_irq_timer.sv
module test_lvt_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_en = 1'b1;
  logic        dl_cap = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dl_we = 1'b0;
  logic [63:0] dl_wdata = '0;
  logic [63:0] dl_rdata;
  logic [63:0] tsc;
  logic        irq;
  logic [7:0]  irq_vec;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tsc <= 64'd1000;
    else        tsc <= tsc + 64'd1;

  lvt_irq_timer i_lvt_irq_timer (
    .clk_i(clk), .rst_ni(rst_n), .sw_en_i(sw_en), .dl_cap_i(dl_cap),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dl_we_i(dl_we), .dl_wdata_i(dl_wdata), .dl_rdata_o(dl_rdata),
    .tsc_i(tsc), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic dlwr(input logic [63:0] d);
    dl_we = 1'b1; dl_wdata = d;
    @(negedge clk);
    dl_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_irq(input int max, output int k);
    bit seen = 1'b0;
    k = -1;
    for (int i = 1; i <= max; i++) begin
      if (!seen) begin
        @(negedge clk);
        if (irq) begin k = i; seen = 1'b1; end
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk(v == 32'h0001_0000, "R1 reset ctrl", v, 32'h0001_0000);
    chk(irq == 1'b0, "R13 reset irq", irq, 0);
    chk(dl_rdata == 64'd0, "R12 reset deadline read", dl_rdata, 0);
    rd(2'd2, v); chk(v == 0, "R6 reset live count", v, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v; int k;
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'd20);
    rd(2'd2, v); chk(v == 32'd20, "R6 live count after start", v, 20);
    wait_irq(40, k); chk(k == 20, "R5 one-shot delay", k, 20);
    chk(irq_vec == 8'h41, "R5 vector", irq_vec, 8'h41);
    wait_irq(60, k); chk(k == -1, "R5 one-shot disarms", k, -1);
  endtask

  task automatic t_divide();
    logic [31:0] v; int k;
    wr(2'd3, 32'd2);
    wr(2'd1, 32'd5);
    rd(2'd2, v); chk(v == 32'd5, "R6 live count scaled", v, 5);
    wait_irq(40, k); chk(k == 20, "R5 divided delay", k, 20);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_periodic();
    int k;
    wr(2'd0, 32'h0002_0042);
    wr(2'd1, 32'd30);
    wait_irq(40, k); chk(k == 30, "R8 first period", k, 30);
    wait_irq(40, k); chk(k == 30, "R8 reload period", k, 30);
    wr(2'd1, 32'd3);
    wait_irq(40, k); chk(k == 16, "R8 clamped first span", k, 16);
    wait_irq(40, k); chk(k == 16, "R8 clamped reload", k, 16);
    wr(2'd1, 32'd0);
    wait_irq(40, k); chk(k == -1, "R7 zero stops periodic", k, -1);
  endtask

  task automatic t_masked();
    logic [31:0] v; int k;
    wr(2'd0, 32'h0001_0044);
    wr(2'd1, 32'd10);
    wait_irq(40, k); chk(k == -1, "R9 masked no request", k, -1);
    rd(2'd2, v); chk(v == 0, "R9 masked one-shot disarmed", v, 0);
  endtask

  task automatic t_restart();
    logic [31:0] v; int k;
    wr(2'd0, 32'h0000_0045);
    wr(2'd1, 32'd50);
    repeat (5) @(negedge clk);
    wr(2'd1, 32'd0);
    wait_irq(80, k); chk(k == -1, "R7 zero write cancels", k, -1);
    rd(2'd2, v); chk(v == 0, "R7 idle after zero", v, 0);
    wr(2'd1, 32'd40);
    repeat (5) @(negedge clk);
    wr(2'd1, 32'd12);
    wait_irq(60, k); chk(k == 12, "R7 restart replaces count", k, 12);
  endtask

  task automatic t_mode_change();
    int k;
    wr(2'd1, 32'd30);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h0002_0045);
    wait_irq(60, k); chk(k == -1, "R4 mode change cancels", k, -1);
    wr(2'd0, 32'h0000_0045);
    wr(2'd1, 32'd30);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h0000_0055);
    wait_irq(40, k); chk(k == 19, "R4 same-mode write keeps countdown", k, 19);
    chk(irq_vec == 8'h55, "R4 updated vector", irq_vec, 8'h55);
  endtask

  task automatic t_dl_port_gated();
    dlwr(64'd123);
    chk(dl_rdata == 0, "R12 deadline reads 0 in one-shot", dl_rdata, 0);
    wr(2'd0, 32'h0004_0046);
    chk(dl_rdata == 0, "R12 write ignored outside deadline", dl_rdata, 0);
  endtask

  task automatic t_deadline();
    logic [31:0] v; logic [63:0] d, d2; int k;
    d = tsc + 64'd40;
    dlwr(d);
    chk(dl_rdata == d, "R10 deadline readback", dl_rdata, d);
    wait_irq(80, k); chk(tsc == d + 64'd1, "R10 fires when tsc reaches deadline", tsc, d + 1);
    chk(irq_vec == 8'h46, "R10 vector", irq_vec, 8'h46);
    wait_irq(30, k); chk(k == -1, "R10 disarms after fire", k, -1);
    dlwr(64'd5);
    wait_irq(10, k); chk(k == 1, "R10 past deadline immediate", k, 1);
    dlwr(64'd0);
    wait_irq(30, k); chk(k == -1, "R10 zero deadline disarmed", k, -1);
    d = tsc + 64'd20;
    dlwr(d);
    d2 = tsc + 64'd60;
    dlwr(d2);
    wait_irq(100, k); chk(tsc == d2 + 64'd1, "R10 rewrite re-arms", tsc, d2 + 1);
    wr(2'd1, 32'd5);
    rd(2'd2, v); chk(v == 0, "R11 live count 0 in deadline", v, 0);
    wait_irq(30, k); chk(k == -1, "R11 start count ignored", k, -1);
    dlwr(tsc + 64'd20);
    wr(2'd0, 32'h0000_0046);
    wait_irq(40, k); chk(k == -1, "R4 mode change cancels deadline", k, -1);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v; int k;
    dl_cap = 1'b0;
    wr(2'd0, 32'h0004_0000);
    rd(2'd0, v); chk(v == 32'h0000_0000, "R2 no deadline bit", v, 0);
    wr(2'd0, 32'h0006_0033);
    rd(2'd0, v); chk(v == 32'h0002_0033, "R2 only low mode bit", v, 32'h0002_0033);
    dl_cap = 1'b1;
    wr(2'd0, 32'h0000_0000);
    sw_en = 1'b0;
    wr(2'd0, 32'h0000_0021);
    rd(2'd0, v); chk(v == 32'h0001_0021, "R3 mask forced", v, 32'h0001_0021);
    sw_en = 1'b1;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h0007_00FF, "R1 extra bits dropped", v, 32'h0007_00FF);
    wr(2'd1, 32'd7);
    wait_irq(30, k); chk(k == -1, "R14 reserved mode idle", k, -1);
    rd(2'd2, v); chk(v == 0, "R14 reserved live count", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_divide();
    t_periodic();
    t_masked();
    t_restart();
    t_mode_change();
    t_dl_port_gated();
    t_deadline();
    t_ctrl_fields();
    summary();
    $finish;
  end
endmodule